// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Selectable Write Policies

This block sits between a processor's load/store port and a single next-level memory port. It keeps a small direct-mapped array of one-word lines. Each line has a tag, a valid bit and a dirty bit. Every request looks up the tag and the data, but only a store modifies the data array. Two run-time inputs select the policies:

- One input picks how a store that hits is handled: the write stays local and marks the line dirty, or it also goes to memory.
- The other input picks how a store that misses is handled: the line is fetched and then written, or the write bypasses the cache.

Writes bound for memory, other than evictions, pass through a four-entry FIFO. The FIFO drains one write at a time whenever the controller is not using the memory port for a miss.

The processor holds its request stable until `coreAck`; `coreStall` is high while a request is pending but not yet acknowledged. A hit is acknowledged in the same cycle it is presented. A miss first waits until the write FIFO is empty. It then writes a dirty victim back, fetches the line and retries the request, which now hits.

Top module: `wcache_top`

## Requirements
- R1: A load that hits is acknowledged in the cycle it is presented, with the line data on `coreRdata`; a load that misses stalls, fetches the word from memory, fills the line and then returns that word.
- R2: With `wbMode`=1 (write-back), a store that hits is acknowledged at once, updates only the cached word, sets the line's dirty bit, and causes no memory write.
- R3: When a line is replaced, a dirty line is written to memory at its old address before the fill read is issued; a clean line is dropped with no memory write.
- R4: With `wbMode`=0 (write-through), a store that hits updates the cached word and queues the same address and data for memory; the line's dirty bit is not set by it.
- R5: With `allocMode`=1 (write-allocate), a store that misses stalls, fetches and fills the line as a load miss would, then performs the store under the current `wbMode` rule.
- R6: With `allocMode`=0 (write-no-allocate), a store that misses leaves the cache contents unchanged and only queues the write for memory; it is acknowledged at once if the FIFO is not full.
- R7: The write FIFO holds 4 entries and writes them to memory in arrival order; a store that needs the FIFO while it is full is stalled until an entry drains.
- R8: A miss never issues its memory read while the write FIFO holds entries, so a load always returns the newest value written to an address.
- R9: Reset clears every valid and dirty bit and empties the write FIFO; queued writes are discarded, and after reset `memReq` and `coreStall` are low.
- R10: Once `memReq` is raised, `memReq`, `memWe`, `memAddr` and `memWdata` hold stable until a cycle with `memReady` high accepts the transfer; read data returns later, flagged by `memRvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbMode | input | 1 | 1 = write-back on store hit, 0 = write-through |
| allocMode | input | 1 | 1 = allocate on store miss, 0 = bypass on store miss |
| coreReq | input | 1 | Processor request pending, held until acknowledged |
| coreWe | input | 1 | 1 = store, 0 = load |
| coreAddr | input | ADDR_W | Word address of the request |
| coreWdata | input | DATA_W | Store data |
| coreRdata | output | DATA_W | Load data, valid with `coreAck` on a load |
| coreAck | output | 1 | Request completes at this clock edge |
| coreStall | output | 1 | Request pending and not completing this cycle |
| memReq | output | 1 | Memory transfer requested |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memReady | input | 1 | Memory accepts the transfer this cycle |
| memRvalid | input | 1 | Read data returned this cycle |
| memRdata | input | DATA_W | Returned read data |

## Verification
- **Hits.** A hit, and a store that may enter a FIFO with room, must show `coreAck` in the same low clock phase in which the request was driven. The bench counts low phases until `coreAck`, so zero stall cycles separates a hit from a miss without knowing the miss latency.
- **Misses.** A miss takes a variable number of cycles set by the memory model's two-cycle read return. For a miss the bench only requires a nonzero stall count and correct load data at the acknowledge.
- **Memory traffic.** FIFO drains run independently of the processor. Memory contents and the cumulative write count are therefore checked only after eight idle cycles, more than enough for four queued entries with `memReady` high.
- **Stalls.** Full-FIFO and drain-before-read stalls are forced by holding `memReady` low for a known number of cycles. The bench then checks that the acknowledge came no earlier.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_EVICT,
    ST_FILLREQ,
    ST_FILLWAIT
  } ctrlState_t;

  typedef struct packed {
    logic wrWord;     // write core data into the addressed line
    logic markDirty;  // set the addressed line's dirty bit
    logic fillLine;   // load memRdata, tag and valid into the line
    logic bufPush;    // queue core address/data into the write FIFO
    logic memOwn;     // controller, not the FIFO, owns the memory port
    logic memRead;    // issue the fill read
    logic memEvict;   // issue the victim writeback
  } dpStrobes_t;

endpackage

// File: rtl/wcache_wbuf.sv
module wcache_wbuf #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cntQ;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      cntQ <= cntQ + 1'b1;
      else if (pop && !push) cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addrMem[wrPtr] <= pushAddr;
      dataMem[wrPtr] <= pushData;
    end
  end

  assign headAddr = addrMem[rdPtr];
  assign headData = dataMem[rdPtr];
  assign empty    = (cntQ == '0);
  assign full     = (cntQ == CNT_W'(DEPTH));
  assign count    = cntQ;
endmodule

// File: rtl/wcache_dp.sv
module wcache_dp
  import wcache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobes_t        st,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] lineData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0]  validQ, dirtyQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] reqTag;

  assign idx    = coreAddr[IDX_W-1:0];
  assign reqTag = coreAddr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (st.fillLine) begin
      validQ[idx] <= 1'b1;
      dirtyQ[idx] <= 1'b0;
    end else if (st.wrWord && st.markDirty) begin
      dirtyQ[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.fillLine) begin
      tagQ[idx]  <= reqTag;
      dataQ[idx] <= memRdata;
    end else if (st.wrWord) begin
      dataQ[idx] <= coreWdata;
    end
  end

  assign hit         = validQ[idx] && (tagQ[idx] == reqTag);
  assign victimDirty = validQ[idx] && dirtyQ[idx];
  assign victimAddr  = {tagQ[idx], idx};
  assign lineData    = dataQ[idx];
endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl
  import wcache_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       coreReq,
  input  logic       coreWe,
  input  logic       wbMode,
  input  logic       allocMode,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       bufEmpty,
  input  logic       bufFull,
  input  logic       memReady,
  input  logic       memRvalid,
  output dpStrobes_t st,
  output logic       coreAck,
  output logic       coreStall
);
  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    st      = '0;
    coreAck = 1'b0;
    stateD  = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (coreReq) begin
          if (!coreWe) begin
            if (hit) coreAck = 1'b1;
            else     stateD  = ST_DRAIN;
          end else if (hit) begin
            if (wbMode) begin
              st.wrWord    = 1'b1;
              st.markDirty = 1'b1;
              coreAck      = 1'b1;
            end else if (!bufFull) begin
              st.wrWord  = 1'b1;
              st.bufPush = 1'b1;
              coreAck    = 1'b1;
            end
          end else if (allocMode) begin
            stateD = ST_DRAIN;
          end else if (!bufFull) begin
            st.bufPush = 1'b1;
            coreAck    = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (bufEmpty) stateD = victimDirty ? ST_EVICT : ST_FILLREQ;
      end
      ST_EVICT: begin
        st.memOwn   = 1'b1;
        st.memEvict = 1'b1;
        if (memReady) stateD = ST_FILLREQ;
      end
      ST_FILLREQ: begin
        st.memOwn  = 1'b1;
        st.memRead = 1'b1;
        if (memReady) stateD = ST_FILLWAIT;
      end
      ST_FILLWAIT: begin
        st.memOwn = 1'b1;
        if (memRvalid) begin
          st.fillLine = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign coreStall = coreReq && !coreAck;
endmodule

// File: rtl/wcache_top.sv
module wcache_top
  import wcache_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int LINES     = 8,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbMode,
  input  logic              allocMode,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] coreRdata,
  output logic              coreAck,
  output logic              coreStall,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int CNT_W = $clog2(BUF_DEPTH+1);

  dpStrobes_t        st;
  logic              hit, victimDirty;
  logic [ADDR_W-1:0] victimAddr, headAddr;
  logic [DATA_W-1:0] lineData, headData;
  logic              bufEmpty, bufFull, bufPop, bufPush;
  logic [CNT_W-1:0]  bufCount;

  wcache_ctrl uCtrl (
    .clk(clk), .rst(rst), .coreReq(coreReq), .coreWe(coreWe),
    .wbMode(wbMode), .allocMode(allocMode), .hit(hit),
    .victimDirty(victimDirty), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .memReady(memReady), .memRvalid(memRvalid), .st(st),
    .coreAck(coreAck), .coreStall(coreStall)
  );

  wcache_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) uDp (
    .clk(clk), .rst(rst), .st(st), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .memRdata(memRdata), .hit(hit),
    .victimDirty(victimDirty), .victimAddr(victimAddr), .lineData(lineData)
  );

  assign bufPush = st.bufPush;
  assign bufPop  = !st.memOwn && !bufEmpty && memReady;

  wcache_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) uBuf (
    .clk(clk), .rst(rst), .push(bufPush), .pushAddr(coreAddr),
    .pushData(coreWdata), .pop(bufPop), .headAddr(headAddr),
    .headData(headData), .empty(bufEmpty), .full(bufFull), .count(bufCount)
  );

  always_comb begin
    if (st.memOwn) begin
      memReq   = st.memRead || st.memEvict;
      memWe    = st.memEvict;
      memAddr  = st.memEvict ? victimAddr : coreAddr;
      memWdata = lineData;
    end else begin
      memReq   = !bufEmpty;
      memWe    = !bufEmpty;
      memAddr  = headAddr;
      memWdata = headData;
    end
  end

  assign coreRdata = lineData;
endmodule

// File: rtl/wcache_chk.sv
module wcache_chk #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              coreAck,
  input logic              coreWe,
  input logic              wbMode,
  input logic              allocMode,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              hit,
  input logic              bufPush,
  input logic              bufEmpty,
  input logic [$clog2(BUF_DEPTH+1)-1:0] bufCount
);
  // R10: a pending memory transfer holds until accepted
  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    memReq && !memReady |=> memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata));

  // R8: fill reads only go out with an empty write FIFO
  a_r8_read_after_drain: assert property (@(posedge clk) disable iff (rst)
    memReq && !memWe |-> bufEmpty);

  // R7: FIFO occupancy never exceeds its depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    bufCount <= ($clog2(BUF_DEPTH+1))'(BUF_DEPTH));

  // R2: write-back store hits queue nothing
  a_r2_wb_hit_local: assert property (@(posedge clk) disable iff (rst)
    coreAck && coreWe && wbMode && hit |-> !bufPush);

  // R6: bypassing store misses always queue the write
  a_r6_noalloc_queues: assert property (@(posedge clk) disable iff (rst)
    coreAck && coreWe && !allocMode && !hit |-> bufPush);

  // R1: a load only completes on a hit
  a_r1_load_ack_hit: assert property (@(posedge clk) disable iff (rst)
    coreAck && !coreWe |-> hit);
endmodule

bind wcache_top wcache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) uChk (
  .clk(clk), .rst(rst), .coreAck(coreAck), .coreWe(coreWe), .wbMode(wbMode),
  .allocMode(allocMode), .memReq(memReq), .memWe(memWe), .memReady(memReady),
  .memAddr(memAddr), .memWdata(memWdata), .hit(hit), .bufPush(bufPush),
  .bufEmpty(bufEmpty), .bufCount(bufCount)
);

// File: tb/tb_wcache_top.sv
`timescale 1ns/1ps
module tb_wcache_top;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbMode = 1'b1, allocMode = 1'b1;
  logic coreReq = 1'b0, coreWe = 1'b0;
  logic [AW-1:0] coreAddr = '0;
  logic [DW-1:0] coreWdata = '0;
  logic [DW-1:0] coreRdata;
  logic coreAck, coreStall;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic memReady = 1'b1;
  logic memRvalid = 1'b0;
  logic [DW-1:0] memRdata = '0;

  always #2 clk = ~clk;

  wcache_top dut (
    .clk(clk), .rst(rst), .wbMode(wbMode), .allocMode(allocMode),
    .coreReq(coreReq), .coreWe(coreWe), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .coreRdata(coreRdata), .coreAck(coreAck),
    .coreStall(coreStall), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRvalid(memRvalid), .memRdata(memRdata)
  );

  // Next-level memory model: reads return two edges after acceptance
  logic [DW-1:0] mem [1024];
  int nWrites = 0;
  logic [DW-1:0] logQ [8];
  int logN = 0;
  logic rdV1 = 1'b0;
  logic [AW-1:0] rdA1 = '0;

  initial for (int i = 0; i < 1024; i++) mem[i] = DW'(i) ^ 16'hA500;

  always @(posedge clk) begin
    memRvalid <= rdV1;
    memRdata  <= mem[rdA1];
    rdV1      <= 1'b0;
    if (memReq && memReady) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        nWrites <= nWrites + 1;
        if (memAddr == 10'h044 && logN < 8) begin
          logQ[logN] <= memWdata;
          logN <= logN + 1;
        end
      end else begin
        rdV1 <= 1'b1;
        rdA1 <= memAddr;
      end
    end
  end

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic wr, input logic wb, input logic al,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output int cyc, output logic [DW-1:0] rd);
    @(negedge clk);
    wbMode = wb; allocMode = al; coreWe = wr; coreAddr = a; coreWdata = d;
    coreReq = 1'b1;
    cyc = 0;
    #1;
    while (!coreAck && cyc < 300) begin
      @(negedge clk); #1;
      cyc++;
    end
    if (cyc >= 300) check("op timeout", 32'(cyc), 32'd0);
    rd = coreRdata;
    @(negedge clk);
    coreReq = 1'b0; coreWe = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  typedef struct packed {
    logic          wr;
    logic          wb;
    logic          al;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          fast;
    logic [DW-1:0] rd;
    logic [AW-1:0] memA;
    logic [DW-1:0] memD;
    logic [7:0]    nWr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,10'h011,16'h0000,1'b0,16'hA511,10'h011,16'hA511,8'd0},
    '{1'b0,1'b1,1'b1,10'h011,16'h0000,1'b1,16'hA511,10'h011,16'hA511,8'd0},
    '{1'b1,1'b1,1'b1,10'h011,16'h1111,1'b1,16'h0000,10'h011,16'hA511,8'd0},
    '{1'b0,1'b1,1'b1,10'h011,16'h0000,1'b1,16'h1111,10'h011,16'hA511,8'd0},
    '{1'b0,1'b1,1'b1,10'h019,16'h0000,1'b0,16'hA519,10'h011,16'h1111,8'd1},
    '{1'b1,1'b0,1'b1,10'h019,16'h2222,1'b1,16'h0000,10'h019,16'h2222,8'd2},
    '{1'b0,1'b0,1'b1,10'h019,16'h0000,1'b1,16'h2222,10'h019,16'h2222,8'd2},
    '{1'b0,1'b0,1'b1,10'h011,16'h0000,1'b0,16'h1111,10'h019,16'h2222,8'd2},
    '{1'b1,1'b1,1'b0,10'h022,16'h3333,1'b1,16'h0000,10'h022,16'h3333,8'd3},
    '{1'b0,1'b1,1'b0,10'h022,16'h0000,1'b0,16'h3333,10'h022,16'h3333,8'd3},
    '{1'b1,1'b1,1'b1,10'h02A,16'h4444,1'b0,16'h0000,10'h02A,16'hA52A,8'd3},
    '{1'b0,1'b1,1'b1,10'h02A,16'h0000,1'b1,16'h4444,10'h02A,16'hA52A,8'd3},
    '{1'b1,1'b0,1'b1,10'h02A,16'h5555,1'b1,16'h0000,10'h02A,16'h5555,8'd4},
    '{1'b0,1'b0,1'b1,10'h022,16'h0000,1'b0,16'h3333,10'h02A,16'h5555,8'd5},
    '{1'b1,1'b0,1'b0,10'h033,16'h6666,1'b1,16'h0000,10'h033,16'h6666,8'd6},
    '{1'b1,1'b0,1'b1,10'h03B,16'h7777,1'b0,16'h0000,10'h03B,16'h7777,8'd7},
    '{1'b0,1'b0,1'b1,10'h03B,16'h0000,1'b1,16'h7777,10'h03B,16'h7777,8'd7},
    '{1'b0,1'b0,1'b0,10'h033,16'h0000,1'b0,16'h6666,10'h033,16'h6666,8'd7}
  };

  initial begin
    int cyc;
    logic [DW-1:0] rd;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: idle outputs after reset
    check("R9 memReq after reset", 32'(memReq), 32'd0);
    check("R9 coreStall after reset", 32'(coreStall), 32'd0);

    for (int v = 0; v < NV; v++) begin
      doOp(VECS[v].wr, VECS[v].wb, VECS[v].al, VECS[v].addr, VECS[v].wdata, cyc, rd);
      check("R1 R5 R6 zero-stall completion", 32'(cyc == 0), 32'(VECS[v].fast));
      if (!VECS[v].wr) check("R1 R8 load data", 32'(rd), 32'(VECS[v].rd));
      settle();
      check("R2 R3 R4 memory word", 32'(mem[VECS[v].memA]), 32'(VECS[v].memD));
      check("R3 R4 R6 memory write count", 32'(nWrites), 32'(VECS[v].nWr));
    end

    // R7: fill the FIFO with memory blocked, fifth store stalls
    base = nWrites;
    memReady = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      doOp(1'b1, 1'b1, 1'b0, 10'h044, DW'(k), cyc, rd);
      check("R7 store into non-full FIFO", 32'(cyc), 32'd0);
    end
    #1;
    // R10: head of FIFO presented and held while not ready
    check("R10 memReq held", 32'(memReq && memWe), 32'd1);
    check("R10 head address", 32'(memAddr), 32'h044);
    check("R10 head data", 32'(memWdata), 32'd1);
    fork
      doOp(1'b1, 1'b1, 1'b0, 10'h044, 16'd5, cyc, rd);
      begin repeat (6) @(negedge clk); memReady = 1'b1; end
    join
    check("R7 full FIFO stalls store", 32'(cyc >= 6), 32'd1);
    settle();
    check("R7 writes drained", 32'(nWrites - base), 32'd5);
    for (int k = 0; k < 5; k++) check("R7 FIFO order", 32'(logQ[k]), 32'(k + 1));

    // R8: load miss waits for the queued write to the same address
    memReady = 1'b0;
    doOp(1'b1, 1'b1, 1'b0, 10'h055, 16'hBEEF, cyc, rd);
    fork
      doOp(1'b0, 1'b1, 1'b0, 10'h055, 16'h0000, cyc, rd);
      begin repeat (3) @(negedge clk); memReady = 1'b1; end
    join
    check("R8 load sees queued write", 32'(rd), 32'hBEEF);
    settle();

    // R9: reset discards queued writes and invalidates lines
    base = nWrites;
    memReady = 1'b0;
    doOp(1'b1, 1'b1, 1'b0, 10'h066, 16'h1234, cyc, rd);
    doOp(1'b1, 1'b1, 1'b0, 10'h067, 16'h5678, cyc, rd);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    #1;
    check("R9 memReq low after reset", 32'(memReq), 32'd0);
    memReady = 1'b1;
    settle();
    check("R9 queued writes dropped", 32'(nWrites - base), 32'd0);
    check("R9 memory untouched", 32'(mem[10'h066]), 32'(16'h0066 ^ 16'hA500));
    doOp(1'b0, 1'b1, 1'b1, 10'h011, 16'h0000, cyc, rd);
    check("R9 lines invalid after reset", 32'(cyc == 0), 32'd0);
    check("R1 R9 refetched data", 32'(rd), 32'h1111);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule